// File: doc/BRIEF.md
# Indexed Byte-Wide Register Window

This block lets a narrow 8-bit strobe bus reach a bank of 32-bit registers inside the core. The bus has a chip select, a read strobe and a write strobe (all active low), a select line that picks between the index register and the data window, and two lane bits that pick one byte of the 32-bit target. Software first writes an index with the select line low. It then reads or writes the addressed register with the select line high, one byte per strobe.

The bank holds an identification word, a read-only version word, a read-only arbitration word and a redirection table of 24 entries of two 32-bit words each. A write to the identification word also reloads the arbitration word with the new ID. The bus strobes are asynchronous to the core clock. Every bus input passes through a synchronizer before it is used, and a write is taken on the synchronized rising edge of the write strobe.

Top module: `regwin_bridge`

## Requirements
- R1: With `sel_data` low, a write loads `data_in` into the 8-bit index on any lane. A read with `sel_data` low returns the index on lane 0 and zero on lanes 1 to 3.
- R2: With `sel_data` high, an access goes to the register selected by the index. `lane` value n selects bits 8n+7:8n of that register.
- R3: A write commits when the write strobe rises while chip select is still asserted. Toggling the write strobe with chip select deasserted changes nothing.
- R4: `data_oe` goes high two core clocks after the read strobe and chip select are both seen low, and then `data_out` carries the selected byte. Otherwise `data_oe` is low.
- R5: While `rst_n` is low, `data_oe` is low. After reset the index, the ID, the arbitration ID and every redirection word read as zero.
- R6: Index 0x00 is the identification word. Only bits 27:24 are writable (they are loaded from `data_in[3:0]` by a lane-3 write), and the other bits read zero. Every write to this word copies its ID into bits 27:24 of the arbitration word at index 0x02.
- R7: Index 0x01 reads 0x00170011, which is version 0x11 with the highest entry number, 23, in bits 23:16. Writes to it are ignored.
- R8: The arbitration word at index 0x02 cannot be written directly.
- R9: Indices 0x10 to 0x3F are 48 read/write redirection words: entry n uses index 0x10+2n for its low word and 0x11+2n for its high word. Each word is stored independently of the others.
- R10: Indices 0x03 to 0x0F and 0x40 to 0xFF read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| sel_data | input | 1 | 0 selects the index register, 1 selects the data window |
| lane | input | 2 | Byte lane within the 32-bit target |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data to the bus |
| data_oe | output | 1 | High when the block drives the bus |

## Verification
A corrupted index sends every later window access to the wrong register, so the next data read returns bytes from another word. This is visible two clocks after the read strobe falls. A wrong write edge detect shows up as a lost or duplicated write, and the read-back of the same lane exposes it. A broken ID-to-arbitration copy shows only when index 0x02 is read after an ID write, so the tests read that word right after each ID write.

// File: rtl/regwin_pkg.sv
// Shared types for the indexed register window.
// Assumes: indices are 8 bits wide; fixed registers sit at indices 0..2.
package regwin_pkg;
    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_RED,
        TGT_NONE
    } tgt_e;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
endpackage

// File: rtl/regwin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous bus inputs.
// Assumes: the bus holds each input stable for several core clocks, so the
// bits of the vector can be synchronized side by side.
module regwin_sync #(
    parameter int          W      = 8,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift stage s of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST;
                else if (s == 0) stg[s] <= d;
                else stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/regwin_bank.sv
// Register bank behind the window: ID, version, arbitration ID and the
// redirection table. Writes are one byte lane at a time.
// Assumes: idx does not change in the cycle after a write.
module regwin_bank
    import regwin_pkg::*;
#(
    parameter int          ENTRIES = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    parameter int          ID_W    = 4,
    parameter logic [7:0]  RED_BASE = 8'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  idx,
    input  logic [1:0]  lane,
    input  logic [7:0]  wdata,
    output logic [31:0] rdata
);
    localparam int         WORDS  = 2 * ENTRIES;
    localparam int         WORD_W = $clog2(WORDS);
    localparam logic [7:0] MAXENT = 8'(ENTRIES - 1);
    localparam logic [8:0] RED_END = 9'(RED_BASE) + 9'(WORDS);

    logic [ID_W-1:0] id_q, arb_q;
    logic [31:0]     red_q [WORDS];
    logic [7:0]      ofs;
    logic [WORD_W-1:0] word;
    tgt_e            tgt;

    assign ofs  = idx - RED_BASE;
    assign word = ofs[WORD_W-1:0];

    // Decode the index into a target register kind.
    always_comb begin
        if (idx == IDX_ID)                                          tgt = TGT_ID;
        else if (idx == IDX_VER)                                    tgt = TGT_VER;
        else if (idx == IDX_ARB)                                    tgt = TGT_ARB;
        else if (idx >= RED_BASE && {1'b0, idx} < RED_END)          tgt = TGT_RED;
        else                                                        tgt = TGT_NONE;
    end

    // Hold the ID; a lane-3 write loads it, any ID write reloads the arbitration ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            arb_q <= '0;
        end else if (we && tgt == TGT_ID) begin
            if (lane == 2'd3) begin
                id_q  <= wdata[ID_W-1:0];
                arb_q <= wdata[ID_W-1:0];
            end else begin
                arb_q <= id_q;
            end
        end
    end

    // Store one byte lane of a redirection word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) red_q[i] <= '0;
        end else if (we && tgt == TGT_RED) begin
            red_q[word][{3'd0, lane} * 5'd8 +: 8] <= wdata;
        end
    end

    // Assemble the 32-bit word seen through the window.
    always_comb begin
        rdata = '0;
        case (tgt)
            TGT_ID:  rdata[24 +: ID_W] = id_q;
            TGT_VER: rdata = {8'h00, MAXENT, 8'h00, VERSION};
            TGT_ARB: rdata[24 +: ID_W] = arb_q;
            TGT_RED: rdata = red_q[word];
            default: rdata = '0;
        endcase
    end

    // R6
    arb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_ID) |=> (arb_q == id_q));

    // R9
    red_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_RED) |=>
        (((rdata >> ({3'd0, $past(lane)} * 5'd8)) & 32'h0000_00FF) == {24'd0, $past(wdata)}));

    // R10
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_NONE) |=> ($stable(id_q) && $stable(arb_q)));
endmodule

// File: rtl/regwin_bridge.sv
// Byte-wide strobe bus to 32-bit register window bridge.
// Synchronizes the bus, keeps the index register, detects writes on the
// synchronized rising write strobe and steers the selected byte lane.
// Assumes: bus inputs are stable for at least SYNC_STAGES+2 clocks per phase.
module regwin_bridge #(
    parameter int         ENTRIES     = 24,
    parameter logic [7:0] VERSION     = 8'h11,
    parameter int         ID_W        = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       sel_data,
    input  logic [1:0] lane,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe
);
    localparam int SW = 14;

    logic [SW-1:0] raw, syn;
    logic       cs_s, rd_s, wr_s, sel_s;
    logic [1:0] lane_s;
    logic [7:0] din_s;
    logic       cs_d, wr_d, sel_d;
    logic [1:0] lane_d;
    logic [7:0] din_d;
    logic [7:0] idx_q;
    logic       wr_fire;
    logic [31:0] word;

    assign raw = {cs_n, rd_n, wr_n, sel_data, lane, data_in};

    regwin_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST({3'b111, 11'd0})) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign {cs_s, rd_s, wr_s, sel_s, lane_s, din_s} = syn;

    // Delay the synchronized bus one clock for edge detect and write capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            wr_d   <= 1'b1;
            sel_d  <= 1'b0;
            lane_d <= '0;
            din_d  <= '0;
        end else begin
            cs_d   <= cs_s;
            wr_d   <= wr_s;
            sel_d  <= sel_s;
            lane_d <= lane_s;
            din_d  <= din_s;
        end
    end

    assign wr_fire = wr_s && !wr_d && !cs_d;

    // Load the index register on a write with the select line low.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idx_q <= '0;
        else if (wr_fire && !sel_d) idx_q <= din_d;
    end

    regwin_bank #(.ENTRIES(ENTRIES), .VERSION(VERSION), .ID_W(ID_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_fire && sel_d), .idx(idx_q),
        .lane(lane_d), .wdata(din_d), .rdata(word)
    );

    // Steer the selected byte and drive only during a selected read.
    always_comb begin
        if (sel_s) data_out = word[{3'd0, lane_s} * 5'd8 +: 8];
        else       data_out = (lane_s == 2'd0) ? idx_q : 8'h00;
        data_oe = rst_n && !rd_s && !cs_s;
    end

    // R1
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !sel_d) |=> (idx_q == $past(din_d)));

    // R3
    no_write_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_d && cs_s) |=> $stable(idx_q));

    // R5
    always_comb begin
        if (!rst_n) release_in_reset_chk: assert (!data_oe);
    end
endmodule

// File: tb/tb_regwin_bridge.sv
module tb_regwin_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_data = 1'b0;
    logic [1:0] lane = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;

    int n_run = 0, n_fail = 0;

    regwin_bridge dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .sel_data(sel_data), .lane(lane), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic       rd;
        logic       sel;
        logic [1:0] ln;
        logic [7:0] val;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 8'h10},  // R1 index -> entry 0 low
        '{1'b0, 1'b1, 2'd0, 8'hA5},  // R9
        '{1'b0, 1'b1, 2'd3, 8'h3C},  // R2 lane 3
        '{1'b1, 1'b1, 2'd0, 8'hA5},
        '{1'b1, 1'b1, 2'd3, 8'h3C},
        '{1'b1, 1'b1, 2'd1, 8'h00},
        '{1'b1, 1'b0, 2'd0, 8'h10},  // R1 index readback
        '{1'b0, 1'b0, 2'd0, 8'h3F},  // R9 last word
        '{1'b0, 1'b1, 2'd2, 8'h77},
        '{1'b1, 1'b1, 2'd2, 8'h77},
        '{1'b0, 1'b0, 2'd0, 8'h11},  // R9 neighbour word
        '{1'b1, 1'b1, 2'd0, 8'h00},
        '{1'b1, 1'b1, 2'd2, 8'h00},
        '{1'b0, 1'b0, 2'd0, 8'h01},  // R7 version
        '{1'b1, 1'b1, 2'd0, 8'h11},
        '{1'b1, 1'b1, 2'd2, 8'h17},
        '{1'b0, 1'b1, 2'd0, 8'hFF},
        '{1'b1, 1'b1, 2'd0, 8'h11},
        '{1'b0, 1'b0, 2'd0, 8'h00},  // R6 ID
        '{1'b0, 1'b1, 2'd3, 8'hF9},
        '{1'b1, 1'b1, 2'd3, 8'h09},
        '{1'b1, 1'b1, 2'd2, 8'h00},
        '{1'b0, 1'b0, 2'd0, 8'h02},  // R6 arbitration copy
        '{1'b1, 1'b1, 2'd3, 8'h09},
        '{1'b0, 1'b1, 2'd3, 8'h05},  // R8 direct write
        '{1'b1, 1'b1, 2'd3, 8'h09},
        '{1'b0, 1'b0, 2'd0, 8'h05},  // R10 unmapped low
        '{1'b0, 1'b1, 2'd0, 8'h5A},
        '{1'b1, 1'b1, 2'd0, 8'h00},
        '{1'b0, 1'b0, 2'd0, 8'h40},  // R10 unmapped high
        '{1'b1, 1'b1, 2'd0, 8'h00},
        '{1'b0, 1'b0, 2'd0, 8'h10},
        '{1'b1, 1'b1, 2'd0, 8'hA5},  // R9 entry 0 intact
        '{1'b1, 1'b0, 2'd2, 8'h00}   // R1 index on lane 0 only
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic s, input logic [1:0] l, input logic [7:0] v, input logic cs);
        @(negedge clk);
        cs_n = cs; sel_data = s; lane = l; data_in = v; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic s, input logic [1:0] l, output logic [7:0] v, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; sel_data = s; lane = l; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        v = data_out; oe = data_oe;
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic oe;
        repeat (4) @(negedge clk);
        check(data_oe == 1'b0, "R5 oe in reset", int'(data_oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 reset state
        bus_read(1'b0, 2'd0, v, oe);
        check(oe && v == 8'h00, "R5 index after reset", int'(v), 0);
        bus_write(1'b0, 2'd0, 8'h20, 1'b0);
        bus_read(1'b1, 2'd1, v, oe);
        check(v == 8'h00, "R5 redirection word after reset", int'(v), 0);

        // R3 write with chip select deasserted
        bus_write(1'b1, 2'd1, 8'hEE, 1'b1);
        bus_read(1'b1, 2'd1, v, oe);
        check(v == 8'h00, "R3 write without chip select", int'(v), 0);
        bus_write(1'b0, 2'd0, 8'h33, 1'b1);
        bus_read(1'b0, 2'd0, v, oe);
        check(v == 8'h20, "R3 index kept without chip select", int'(v), 8'h20);

        // R4 idle and latency
        check(data_oe == 1'b0, "R4 idle bus released", int'(data_oe), 0);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; sel_data = 1'b0; lane = 2'd0;
        @(negedge clk);
        check(data_oe == 1'b0, "R4 oe after one clock", int'(data_oe), 0);
        @(negedge clk);
        check(data_oe == 1'b1, "R4 oe after two clocks", int'(data_oe), 1);
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
        check(data_oe == 1'b0, "R4 oe after strobe release", int'(data_oe), 0);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (!VECS[i].rd) begin
                bus_write(VECS[i].sel, VECS[i].ln, VECS[i].val, 1'b0);
            end else begin
                bus_read(VECS[i].sel, VECS[i].ln, v, oe);
                n_run++;
                if (!oe || v != VECS[i].val) begin
                    n_fail++;
                    $display("FAIL R2 vector %0d actual=%0h oe=%0d expected=%0h", i, v, oe, VECS[i].val);
                end
            end
        end

        // R5 reset during a read releases the bus and clears state
        bus_write(1'b0, 2'd0, 8'h00, 1'b0);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; sel_data = 1'b1; lane = 2'd3;
        repeat (3) @(negedge clk);
        check(data_oe == 1'b1 && data_out == 8'h09, "R6 ID before reset", int'(data_out), 8'h09);
        rst_n = 1'b0;
        #1;
        check(data_oe == 1'b0, "R5 release at reset", int'(data_oe), 0);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(1'b1, 2'd3, v, oe);
        check(v == 8'h00, "R5 ID cleared by reset", int'(v), 0);
        bus_write(1'b0, 2'd0, 8'h10, 1'b0);
        bus_read(1'b1, 2'd0, v, oe);
        check(v == 8'h00, "R5 table cleared by reset", int'(v), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule